// File: doc/BRIEF.md
# Shared-Word Concurrent Write Resolver

This block stands in front of a single shared storage word that several processor ports reach on one common clock. In any cycle each port may make one access: a write, with a data value, or a read. When more than one port writes in the same cycle, the block settles the collision under a policy chosen on the `mode_i` input. Four policies are available. Exclusive treats any collision as illegal. Common accepts a collision only when every writer offers the same value. Arbitrary lets one writer through, chosen by a rotating pointer. Priority lets the lowest-numbered port through.

A chosen write updates the word at the end of its cycle. Readers always see the stored word on one broadcast output, so a read in the same cycle as a write returns the old value. A separate input makes reads exclusive. In that state, two or more readers in one cycle is illegal.

Every illegal pattern raises a one-cycle violation pulse and sets an error flag. The flag stays set until reset. An illegal write pattern leaves the word unchanged.

Top module: `share_word_resolver`

## Requirements
- R1: After reset the word is 0, the commit, violation and error outputs are 0, `win_idx_o` is 0, and the rotating pointer is at port 0.
- R2: Mode 2'b00 (exclusive). With exactly one writer, that writer's value is committed. With two or more writers, nothing is committed, the word is unchanged and a violation is flagged.
- R3: Mode 2'b01 (common). With one or more writers that all present the same value, that value is committed. If any two writers differ, nothing is committed, the word is unchanged and a violation is flagged.
- R4: Mode 2'b10 (arbitrary). With one or more writers, the winner is the first writing port met when scanning upward from the pointer and wrapping past the highest port. The pointer starts at 0. After each commit in this mode it moves to the winner plus one, wrapping to 0. No other mode moves the pointer.
- R5: Mode 2'b11 (priority). With one or more writers, the writer with the smallest port number is committed.
- R6: In a cycle with no writers, nothing is committed and the word is unchanged, in every mode.
- R7: `rd_data_o` always shows the stored word. A write committed in a cycle becomes visible there only in the next cycle.
- R8: When `rd_excl_i` is 1 and two or more ports read, `rd_gnt_o` is 0 and a violation is flagged. Otherwise `rd_gnt_o` equals `rd_vld_i`. This output is combinational.
- R9: `viol_o` is 1 in the cycle after an illegal write or read pattern. `err_o` becomes 1 at the same time and stays 1 until reset.
- R10: `commit_o` pulses in the cycle after a committed write. `win_idx_o` then holds the winning port number, and it keeps that value until the next commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Write policy: 00 exclusive, 01 common, 10 arbitrary, 11 priority |
| rd_excl_i | input | 1 | 1 makes concurrent reads illegal |
| wr_vld_i | input | NPORT | Write request, one bit per port |
| wr_data_i | input | NPORT*DW | Write values, port i at bits i*DW and up |
| rd_vld_i | input | NPORT | Read request, one bit per port |
| rd_gnt_o | output | NPORT | Readers served this cycle |
| rd_data_o | output | DW | Stored word, broadcast to all readers |
| commit_o | output | 1 | A write was committed in the previous cycle |
| win_idx_o | output | IW | Port number of the last committed writer |
| viol_o | output | 1 | The previous cycle held an illegal pattern |
| err_o | output | 1 | Sticky error flag |

## Verification
Every write mask of a four-port configuration is applied under every policy, with both read settings and with three kinds of data. One data set has all values equal, which tells common mode's accept case from exclusive mode's reject case. One has all values distinct, which exposes common-mode disagreement and shows which port won in the other policies. The third is pseudo-random. Running the masks in a fixed order through arbitrary mode moves the pointer through every position, so a wrong wrap or a stuck pointer shows up as a wrong winner. Reading in the same cycle as a write shows that the old word is returned and the new one appears a cycle later.

// File: rtl/swr_pkg.sv
// Shared types for the shared-word write resolver.
package swr_pkg;
    typedef enum logic [1:0] {
        MD_EXCL   = 2'b00,
        MD_COMMON = 2'b01,
        MD_ARB    = 2'b10,
        MD_PRIO   = 2'b11
    } swr_mode_e;
endpackage

// File: rtl/swr_wdetect.sv
// Write detector: counts the writers, finds the lowest-numbered one, and
// tells whether every writer offers the same value as that lowest writer.
// Assumes wr_data is packed with port i at bits [i*DW +: DW].
module swr_wdetect #(
    parameter int NPORT = 4,
    parameter int DW    = 8,
    localparam int IW   = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int CW   = $clog2(NPORT + 1)
) (
    input  logic [NPORT-1:0]    vld,
    input  logic [NPORT*DW-1:0] data,
    output logic [CW-1:0]       cnt,
    output logic [IW-1:0]       low_idx,
    output logic                agree
);
    logic [DW-1:0] lane [NPORT];

    // unpack the flat data bus into one lane per port
    for (genvar g = 0; g < NPORT; g++) begin : g_lane
        assign lane[g] = data[g*DW +: DW];
    end

    // lowest writer, obtained by scanning from the top port down
    always_comb begin
        low_idx = '0;
        for (int i = NPORT - 1; i >= 0; i--) begin
            if (vld[i]) low_idx = IW'(i);
        end
    end

    // writer count and value agreement with the lowest writer
    always_comb begin
        cnt   = '0;
        agree = 1'b1;
        for (int i = 0; i < NPORT; i++) begin
            if (vld[i]) begin
                cnt = cnt + CW'(1);
                if (lane[i] != lane[low_idx]) agree = 1'b0;
            end
        end
    end
endmodule

// File: rtl/swr_rotpick.sv
// Rotating picker: returns the first requesting port at or above ptr,
// wrapping past the highest port. Assumes ptr < NPORT.
module swr_rotpick #(
    parameter int NPORT = 4,
    localparam int IW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic [NPORT-1:0] vld,
    input  logic [IW-1:0]    ptr,
    output logic [IW-1:0]    win
);
    // scan the offsets from the farthest back to the nearest, so the nearest one wins
    always_comb begin
        win = ptr;
        for (int k = NPORT - 1; k >= 0; k--) begin
            int j;
            j = int'(ptr) + k;
            if (j >= NPORT) j = j - NPORT;
            if (vld[j]) win = IW'(j);
        end
    end
endmodule

// File: rtl/swr_rdgate.sv
// Read gate: serves all readers, unless reads are exclusive and there is
// more than one reader, in which case no reader is served and a violation is raised.
module swr_rdgate #(
    parameter int NPORT = 4
) (
    input  logic [NPORT-1:0] rd_vld,
    input  logic             rd_excl,
    output logic [NPORT-1:0] rd_gnt,
    output logic             rd_bad
);
    // reader legality check and grant
    always_comb begin
        rd_bad = rd_excl && ($countones(rd_vld) > 1);
        rd_gnt = rd_bad ? '0 : rd_vld;
    end
endmodule

// File: rtl/share_word_resolver.sv
// Shared-word concurrent write resolver. Each cycle it chooses at most one
// write for the stored word, under the policy on mode_i, and flags illegal
// concurrency. Assumes that no port requests a read and a write in the
// same cycle, and that all ports share clk.
module share_word_resolver
    import swr_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int DW    = 8,
    localparam int IW   = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int CW   = $clog2(NPORT + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          mode_i,
    input  logic                rd_excl_i,
    input  logic [NPORT-1:0]    wr_vld_i,
    input  logic [NPORT*DW-1:0] wr_data_i,
    input  logic [NPORT-1:0]    rd_vld_i,
    output logic [NPORT-1:0]    rd_gnt_o,
    output logic [DW-1:0]       rd_data_o,
    output logic                commit_o,
    output logic [IW-1:0]       win_idx_o,
    output logic                viol_o,
    output logic                err_o
);
    logic [CW-1:0] w_cnt;
    logic [IW-1:0] low_idx, rot_win, ptr_q, sel_idx, ptr_nxt;
    logic          agree, rd_bad, do_commit, wr_bad;
    logic [DW-1:0] word_q;
    swr_mode_e     md;

    assign md = swr_mode_e'(mode_i);

    swr_wdetect #(.NPORT(NPORT), .DW(DW)) wdet_i (
        .vld(wr_vld_i), .data(wr_data_i), .cnt(w_cnt),
        .low_idx(low_idx), .agree(agree)
    );

    swr_rotpick #(.NPORT(NPORT)) rot_i (
        .vld(wr_vld_i), .ptr(ptr_q), .win(rot_win)
    );

    swr_rdgate #(.NPORT(NPORT)) rdg_i (
        .rd_vld(rd_vld_i), .rd_excl(rd_excl_i),
        .rd_gnt(rd_gnt_o), .rd_bad(rd_bad)
    );

    // policy decision: which writer commits and whether the write pattern is illegal
    always_comb begin
        do_commit = 1'b0;
        wr_bad    = 1'b0;
        sel_idx   = low_idx;
        case (md)
            MD_EXCL: begin
                do_commit = (w_cnt == CW'(1));
                wr_bad    = (w_cnt > CW'(1));
            end
            MD_COMMON: begin
                do_commit = (w_cnt != '0) && agree;
                wr_bad    = (w_cnt != '0) && !agree;
            end
            MD_ARB: begin
                do_commit = (w_cnt != '0);
                sel_idx   = rot_win;
            end
            default: begin
                do_commit = (w_cnt != '0);
            end
        endcase
    end

    // pointer successor of the arbitrary-mode winner, wrapping to port 0
    always_comb begin
        if (rot_win == IW'(NPORT - 1)) ptr_nxt = '0;
        else                           ptr_nxt = rot_win + IW'(1);
    end

    // stored word, commit report and rotating pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q    <= '0;
            commit_o  <= 1'b0;
            win_idx_o <= '0;
            ptr_q     <= '0;
        end else begin
            commit_o <= do_commit;
            if (do_commit) begin
                word_q    <= wr_data_i[sel_idx*DW +: DW];
                win_idx_o <= sel_idx;
                if (md == MD_ARB) ptr_q <= ptr_nxt;
            end
        end
    end

    // violation pulse and sticky error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_o <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            viol_o <= wr_bad || rd_bad;
            if (wr_bad || rd_bad) err_o <= 1'b1;
        end
    end

    assign rd_data_o = word_q;
endmodule

// File: rtl/swr_chk.sv
// Checker for share_word_resolver: temporal properties over its ports.
module swr_chk #(
    parameter int NPORT = 4,
    parameter int DW    = 8,
    localparam int IW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_i,
    input logic [NPORT-1:0] wr_vld_i,
    input logic [NPORT-1:0] rd_vld_i,
    input logic [NPORT-1:0] rd_gnt_o,
    input logic [DW-1:0]    rd_data_o,
    input logic             commit_o,
    input logic [IW-1:0]    win_idx_o,
    input logic             viol_o,
    input logic             err_o
);
    logic [NPORT-1:0] prev_vld;
    logic [1:0]       prev_mode;
    logic [DW-1:0]    prev_word;

    // record the previous cycle's requests, mode and word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_vld  <= '0;
            prev_mode <= '0;
            prev_word <= '0;
        end else begin
            prev_vld  <= wr_vld_i;
            prev_mode <= mode_i;
            prev_word <= rd_data_o;
        end
    end

    AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_o |-> (rd_data_o == prev_word)); // R6
    AST_EXCL_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_o && prev_mode == 2'b00) |-> ($countones(prev_vld) == 1)); // R2
    AST_WINNER_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> prev_vld[win_idx_o]); // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o); // R9
    AST_VIOL_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> err_o); // R9
    AST_GNT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_gnt_o & ~rd_vld_i) == '0)); // R8
endmodule

bind share_word_resolver swr_chk #(.NPORT(NPORT), .DW(DW)) chk_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .wr_vld_i(wr_vld_i),
    .rd_vld_i(rd_vld_i), .rd_gnt_o(rd_gnt_o), .rd_data_o(rd_data_o),
    .commit_o(commit_o), .win_idx_o(win_idx_o), .viol_o(viol_o), .err_o(err_o)
);

// File: tb/share_word_resolver_tb.sv
// Bench: sweeps every mode, read setting, write mask and data kind on a
// four-port, four-bit configuration against an arithmetic model.
module share_word_resolver_tb_top;
    localparam int NP = 4;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode_i = '0;
    logic          rd_excl_i = 1'b0;
    logic [NP-1:0] wr_vld_i = '0;
    logic [NP*DW-1:0] wr_data_i = '0;
    logic [NP-1:0] rd_vld_i = '0;
    logic [NP-1:0] rd_gnt_o;
    logic [DW-1:0] rd_data_o;
    logic          commit_o;
    logic [1:0]    win_idx_o;
    logic          viol_o;
    logic          err_o;

    int n_chk = 0;
    int n_fail = 0;
    int ref_word = 0, ref_ptr = 0, ref_win = 0, ref_err = 0;
    int lcg = 7;

    share_word_resolver #(.NPORT(NP), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .rd_excl_i(rd_excl_i),
        .wr_vld_i(wr_vld_i), .wr_data_i(wr_data_i), .rd_vld_i(rd_vld_i),
        .rd_gnt_o(rd_gnt_o), .rd_data_o(rd_data_o), .commit_o(commit_o),
        .win_idx_o(win_idx_o), .viol_o(viol_o), .err_o(err_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int md, input bit rx, input int wm, input int rm, input int pat);
        int d [NP];
        int nw, nr, low, win, okc, vw, vr, agree;
        string tag;
        for (int i = 0; i < NP; i++) begin
            if (pat == 0) d[i] = 10;
            else if (pat == 1) d[i] = i + 2;
            else begin
                lcg = (lcg * 13 + 5) % 16;
                d[i] = lcg;
            end
        end
        mode_i    = 2'(md);
        rd_excl_i = rx;
        wr_vld_i  = NP'(wm);
        rd_vld_i  = NP'(rm);
        for (int i = 0; i < NP; i++) wr_data_i[i*DW +: DW] = DW'(d[i]);
        // model
        nw = 0; nr = 0; low = -1; agree = 1;
        for (int i = 0; i < NP; i++) begin
            if (wm[i]) begin
                nw++;
                if (low < 0) low = i;
                else if (d[i] != d[low]) agree = 0;
            end
            if (rm[i]) nr++;
        end
        win = low; okc = 0; vw = 0;
        case (md)
            0: begin okc = (nw == 1); vw = (nw > 1); end
            1: begin okc = (nw >= 1) && agree; vw = (nw >= 1) && !agree; end
            2: begin
                okc = (nw >= 1);
                for (int k = NP - 1; k >= 0; k--)
                    if (wm[(ref_ptr + k) % NP]) win = (ref_ptr + k) % NP;
            end
            default: okc = (nw >= 1);
        endcase
        vr = rx && (nr > 1);
        tag = (wm == 0) ? "R6" : (md == 0) ? "R2" : (md == 1) ? "R3" : (md == 2) ? "R4" : "R5";
        #1;
        chk("R7", "same-cycle read", int'(rd_data_o), ref_word);
        chk("R8", "read grant", int'(rd_gnt_o), vr ? 0 : rm);
        @(posedge clk);
        @(negedge clk);
        if (okc) begin
            ref_word = d[win];
            ref_win  = win;
            if (md == 2) ref_ptr = (win + 1) % NP;
        end
        if (vw || vr) ref_err = 1;
        chk(tag, "commit", int'(commit_o), okc);
        chk(tag, "word", int'(rd_data_o), ref_word);
        chk("R10", "winner", int'(win_idx_o), ref_win);
        chk("R9", "violation", int'(viol_o), (vw || vr) ? 1 : 0);
        chk("R9", "sticky error", int'(err_o), ref_err);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "reset word", int'(rd_data_o), 0);
        chk("R1", "reset commit", int'(commit_o), 0);
        chk("R1", "reset violation", int'(viol_o), 0);
        chk("R1", "reset error", int'(err_o), 0);
        chk("R1", "reset winner", int'(win_idx_o), 0);
        // first arbitrary write after reset: pointer must start at port 0
        step(2, 0, 4'b1111, 0, 1);
        chk("R1", "pointer start", int'(win_idx_o), 0);
        for (int md = 0; md < 4; md++)
            for (int rx = 0; rx < 2; rx++)
                for (int wm = 0; wm < 16; wm++)
                    for (int pat = 0; pat < 3; pat++)
                        step(md, rx[0], wm, (wm * 5 + pat * 3) % 16, pat);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule